// File: doc/BRIEF.md
# Synthesizer Serial Control Port with Fastlock Timer

This block is the control front end of a frequency synthesizer. A host writes 24-bit words over three wires: a serial clock, a data line and a load strobe. Each word goes to one of four destinations: a reference-divider word, a swallow/main counter word, a function word, or an initialization word that also loads the function word. The port also produces the internal counter reset. It combines the programmed power-down modes with a chip-enable pin and drives the charge-pump tri-state. It selects the active charge-pump current code.

The three serial lines are sampled in the system clock domain and treated as synchronous to it. A rising edge of a serial line is seen as a low-to-high change between two clock samples. Words with the wrong bit count are dropped. A fastlock timer counts phase-detector event strobes. While the fastlock gain bit is set, the charge pump uses the secondary current code. When the timer expires it clears that bit, and the primary code returns.

Top module: `synth_ctrl_port`

## Requirements
- R1: After reset, `ref_word`, `ab_word` and `func_word` are zero, `cnt_reset` is 0, `cp_code` is 0 and `pwr_down` equals the inverse of `chip_en`.
- R2: Data is shifted MSB first on each rising `ser_clk`. On a rising `ser_le`, bits [1:0] of the word pick the target: 00 goes to `ref_word`, 01 to `ab_word`, and 10 or 11 to `func_word`. The new value shows from the clock edge that samples the `ser_le` rise.
- R3: A word is committed only if exactly 24 rising `ser_clk` edges were seen since the previous `ser_le` rise. Otherwise it is discarded and all latches are left unchanged. Every `ser_le` rise restarts the bit count.
- R4: A commit with bits [1:0]=11 raises `cnt_reset` for exactly one clock cycle. So does the first 01 commit after it. Later 01 commits do not, until the next 11 commit.
- R5: While bit 2 of `func_word` is 1, `cnt_reset` stays high.
- R6: If bit 3 of `func_word` is 1 and bit 21 is 0, `pwr_down` is high at once.
- R7: If bits 3 and 21 of `func_word` are both 1, `pwr_down` goes high on the clock edge that samples the next `pd_event`. It stays high until bit 3 is written 0.
- R8: A low `chip_en` forces `pwr_down` high in the same cycle, whatever the function word holds. Serial writes are still accepted while it is low.
- R9: `cp_tristate` is high exactly when `pwr_down`, `cnt_reset` or bit 8 of `func_word` is high.
- R10: `cp_code` takes `func_word[20:18]` when fastlock is enabled (`func_word[9]`=1) and the gain bit `ab_word[21]` is 1. Otherwise it takes `func_word[17:15]`.
- R11: In fastlock mode 2 (`func_word[10]`=1 and bit 9 = 1), the gain bit is cleared in `ab_word` after (TC+1)×4 `pd_event` strobes, where TC is `func_word[14:11]`. Strobes count only while the gain bit is set and neither `pwr_down` nor `cnt_reset` is high. Any 01 commit restarts the count.
- R12: In fastlock mode 1 (`func_word[10]`=0), the gain bit changes only through 01 commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge commits the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| pd_event | input | 1 | One-cycle strobe per phase-detector event |
| ref_word | output | 24 | Reference-divider latch |
| ab_word | output | 24 | Counter latch; bit 21 is the fastlock gain bit |
| func_word | output | 24 | Function latch |
| cnt_reset | output | 1 | Holds the dividers and timers at their load point |
| pwr_down | output | 1 | Power-down state |
| cp_tristate | output | 1 | Charge-pump output disabled |
| cp_code | output | 3 | Active charge-pump current code |

## Verification
Several rules are checked on every clock cycle. A reset pulse only follows a load-strobe edge. A low chip enable always tri-states the pump. A synchronous power-down only starts on an event strobe. The timeout counter never reaches its limit. The function word holds between commits. The gain bit stays fixed in mode 1 unless a counter word is written.

Other behaviour needs the bench's scenarios. These cover the pulse being produced once for an initialization and once for the first counter write after it, and malformed word lengths being dropped. They also cover the exact strobe count at which the gain bit clears, and the ordering of power-down sources. A behavioural model is compared against all outputs on every cycle.

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port #(
  parameter int WORD_W    = 24,
  parameter int TC_W      = 4,
  parameter int TICK_MULT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  input  logic              chip_en,
  input  logic              pd_event,
  output logic [WORD_W-1:0] ref_word,
  output logic [WORD_W-1:0] ab_word,
  output logic [WORD_W-1:0] func_word,
  output logic              cnt_reset,
  output logic              pwr_down,
  output logic              cp_tristate,
  output logic [2:0]        cp_code
);

  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int TICK_W = $clog2((1 << TC_W) * TICK_MULT + 1);
  localparam logic [1:0] SEL_REF  = 2'b00;
  localparam logic [1:0] SEL_AB   = 2'b01;
  localparam logic [1:0] SEL_INIT = 2'b11;

  logic              sclk_q, le_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;
  logic              first_ab, rst_pulse, sync_pd;
  logic [TICK_W-1:0] ticks;

  wire sclk_rise = ser_clk & ~sclk_q;
  wire le_rise   = ser_le & ~le_q;
  wire commit    = le_rise && (nbits == CNT_W'(WORD_W));
  wire [1:0] sel = shreg[1:0];
  wire commit_ab = commit && (sel == SEL_AB);

  wire              hold_rst = func_word[2];
  wire              pd1      = func_word[3];
  wire              cp3s     = func_word[8];
  wire              fl_en    = func_word[9];
  wire              fl_mode2 = func_word[10];
  wire [TC_W-1:0]   tc       = func_word[14:11];
  wire [2:0]        cur1     = func_word[17:15];
  wire [2:0]        cur2     = func_word[20:18];
  wire              pd2      = func_word[21];
  wire              gain     = ab_word[21];

  wire [TICK_W-1:0] tc_ext = TICK_W'(tc);
  wire [TICK_W-1:0] limit  = (tc_ext + TICK_W'(1)) * TICK_W'(TICK_MULT);

  assign cnt_reset   = rst_pulse | hold_rst;
  assign pwr_down    = ~chip_en | (pd1 & ~pd2) | sync_pd;
  assign cp_tristate = pwr_down | cnt_reset | cp3s;
  assign cp_code     = (fl_en & gain) ? cur2 : cur1;

  wire tmr_run  = fl_en & fl_mode2 & gain & ~pwr_down & ~cnt_reset;
  wire tmr_done = tmr_run & pd_event & (ticks == limit - TICK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      shreg  <= '0;
      nbits  <= '0;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_le;
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], ser_data};
      if (le_rise) nbits <= '0;
      else if (sclk_rise && nbits != '1) nbits <= nbits + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_word  <= '0;
      func_word <= '0;
      ab_word   <= '0;
    end else begin
      if (commit && sel == SEL_REF) ref_word <= shreg;
      if (commit && sel[1]) func_word <= shreg;
      if (commit_ab) ab_word <= shreg;
      else if (tmr_done) ab_word[21] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_ab  <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= commit && (sel == SEL_INIT || (sel == SEL_AB && first_ab));
      if (commit && sel == SEL_INIT) first_ab <= 1'b1;
      else if (commit_ab) first_ab <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_pd <= 1'b0;
    else        sync_pd <= pd1 & pd2 & (sync_pd | pd_event);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ticks <= '0;
    else if (commit_ab || !tmr_run) ticks <= '0;
    else if (pd_event)          ticks <= tmr_done ? '0 : ticks + TICK_W'(1);
  end

  assert_pulse_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> $past(le_rise));

  assert_ce_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> cp_tristate);

  assert_sync_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pd) |-> $past(pd_event));

  assert_tick_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ticks < limit);

  assert_mode1_gain_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(commit_ab) && !$past(fl_mode2)) |-> $stable(ab_word[21]));

  assert_func_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(func_word));

endmodule

// File: tb/test_synth_ctrl_port.sv
module test_synth_ctrl_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 0, ser_data = 0, ser_le = 0, chip_en = 1, pd_event = 0;
  logic [23:0] ref_word, ab_word, func_word;
  logic cnt_reset, pwr_down, cp_tristate;
  logic [2:0] cp_code;

  synth_ctrl_port i_synth_ctrl_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .chip_en(chip_en), .pd_event(pd_event),
    .ref_word(ref_word), .ab_word(ab_word), .func_word(func_word),
    .cnt_reset(cnt_reset), .pwr_down(pwr_down), .cp_tristate(cp_tristate),
    .cp_code(cp_code));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [23:0] m_sh, m_ref, m_ab, m_func, w;
  int m_nb, m_tick;
  logic m_sclk_q, m_le_q, m_first, m_pulse, m_sync;
  logic commit, timeout, pwr, crst;

  function automatic logic exp_pwr();
    return !chip_en || (m_func[3] && !m_func[21]) || m_sync;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 0; m_ref = 0; m_ab = 0; m_func = 0; m_nb = 0; m_tick = 0;
      m_sclk_q = 0; m_le_q = 0; m_first = 0; m_pulse = 0; m_sync = 0;
    end else begin
      w = m_sh;
      commit = ser_le && !m_le_q && m_nb == 24;
      pwr = exp_pwr();
      crst = m_pulse || m_func[2];
      timeout = 0;
      if (commit && w[1:0] == 2'b01) m_tick = 0;
      else if (!(m_func[9] && m_func[10] && m_ab[21]) || pwr || crst) m_tick = 0;
      else if (pd_event) begin
        if (m_tick == (int'(m_func[14:11]) + 1) * 4 - 1) begin timeout = 1; m_tick = 0; end
        else m_tick++;
      end
      m_sync = m_func[3] && m_func[21] && (m_sync || pd_event);
      m_pulse = commit && (w[1:0] == 2'b11 || (w[1:0] == 2'b01 && m_first));
      if (commit && w[1:0] == 2'b11) m_first = 1;
      else if (commit && w[1:0] == 2'b01) m_first = 0;
      if (commit) begin
        case (w[1:0])
          2'b00: m_ref = w;
          2'b01: m_ab = w;
          default: m_func = w;
        endcase
      end else if (timeout) m_ab[21] = 0;
      if (ser_le && !m_le_q) m_nb = 0;
      else if (ser_clk && !m_sclk_q && m_nb < 31) m_nb++;
      if (ser_clk && !m_sclk_q) m_sh = {m_sh[22:0], ser_data};
      m_sclk_q = ser_clk; m_le_q = ser_le;
    end
    #2;
    chk(ref_word === m_ref, "R2 ref_word", ref_word, m_ref);
    chk(ab_word === m_ab, "R11 ab_word", ab_word, m_ab);
    chk(func_word === m_func, "R2 func_word", func_word, m_func);
    chk(cnt_reset === (m_pulse || m_func[2]), "R4 cnt_reset", 24'(cnt_reset), 24'(m_pulse || m_func[2]));
    chk(pwr_down === exp_pwr(), "R6 pwr_down", 24'(pwr_down), 24'(exp_pwr()));
    chk(cp_tristate === (exp_pwr() || m_pulse || m_func[2] || m_func[8]), "R9 cp_tristate",
        24'(cp_tristate), 24'(exp_pwr() || m_pulse || m_func[2] || m_func[8]));
    chk(cp_code === ((m_func[9] && m_ab[21]) ? m_func[20:18] : m_func[17:15]), "R10 cp_code",
        24'(cp_code), 24'((m_func[9] && m_ab[21]) ? m_func[20:18] : m_func[17:15]));
    if (cnt_reset === 1'b1) pulses++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [23:0] wd, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) begin ser_data = wd[i % 24]; ser_clk = 0; end
      @(negedge clk) ser_clk = 1;
    end
    @(negedge clk) ser_clk = 0;
    @(negedge clk) ser_le = 1;
    @(negedge clk) ser_le = 0;
    @(negedge clk);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pd_event = 1;
      @(negedge clk) pd_event = 0;
    end
  endtask

  logic [23:0] fw, fw1;
  int p0;

  initial begin
    fw  = (24'd6 << 18) | (24'd3 << 15) | (24'd1 << 11) | (24'd1 << 10) | (24'd1 << 9) | 24'd3;
    fw1 = (fw & ~24'h000403) | 24'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ref_word == 0 && ab_word == 0 && func_word == 0, "R1 latches", ab_word, 0);
    chk(cnt_reset == 0 && cp_code == 0 && pwr_down == 0, "R1 outputs", 24'(cp_code), 0);

    send(24'h0ABC00, 24);
    chk(ref_word == 24'h0ABC00, "R2 ref write", ref_word, 24'h0ABC00);

    p0 = pulses;
    send(fw, 24);
    chk(func_word == fw, "R2 init loads func", func_word, fw);
    chk(pulses - p0 == 1, "R4 init pulse", 24'(pulses - p0), 1);

    p0 = pulses;
    send((24'd1 << 21) | (24'd100 << 8) | (24'd5 << 2) | 24'd1, 24);
    chk(pulses - p0 == 1, "R4 first AB pulse", 24'(pulses - p0), 1);
    chk(cp_code == 3'd6, "R10 secondary code", 24'(cp_code), 6);
    strobe(7);
    chk(ab_word[21] == 1, "R11 before timeout", 24'(ab_word[21]), 1);
    strobe(1);
    chk(ab_word[21] == 0, "R11 gain cleared", 24'(ab_word[21]), 0);
    chk(cp_code == 3'd3, "R10 primary code", 24'(cp_code), 3);

    p0 = pulses;
    send((24'd1 << 21) | (24'd7 << 8) | 24'd1, 24);
    chk(pulses - p0 == 0, "R4 no second pulse", 24'(pulses - p0), 0);

    send(fw1, 24);
    strobe(20);
    chk(ab_word[21] == 1, "R12 mode1 keeps gain", 24'(ab_word[21]), 1);
    send((24'd7 << 8) | 24'd1, 24);
    chk(ab_word[21] == 0, "R12 write clears gain", 24'(ab_word[21]), 0);

    send(24'h055500, 23);
    chk(ref_word == 24'h0ABC00, "R3 short word dropped", ref_word, 24'h0ABC00);
    send(24'h055500, 25);
    chk(ref_word == 24'h0ABC00, "R3 long word dropped", ref_word, 24'h0ABC00);
    send(24'h055500, 24);
    chk(ref_word == 24'h055500, "R3 exact word kept", ref_word, 24'h055500);

    send(fw1 | 24'h4, 24);
    repeat (3) @(negedge clk);
    chk(cnt_reset == 1 && cp_tristate == 1, "R5 counter hold", 24'(cnt_reset), 1);

    send(fw1 | 24'h8, 24);
    chk(pwr_down == 1, "R6 async power-down", 24'(pwr_down), 1);

    send(fw1 | 24'h8 | (24'd1 << 21), 24);
    chk(pwr_down == 0, "R7 waits for event", 24'(pwr_down), 0);
    strobe(1);
    chk(pwr_down == 1, "R7 sync power-down", 24'(pwr_down), 1);
    send(fw1, 24);
    chk(pwr_down == 0, "R7 released", 24'(pwr_down), 0);

    send(fw1 | 24'h100, 24);
    chk(cp_tristate == 1 && pwr_down == 0, "R9 tri-state bit", 24'(cp_tristate), 1);
    send(fw1, 24);

    @(negedge clk) chip_en = 0;
    #1 chk(pwr_down == 1 && cp_tristate == 1, "R8 chip enable low", 24'(pwr_down), 1);
    send(24'h012300, 24);
    chk(ref_word == 24'h012300, "R8 write while down", ref_word, 24'h012300);
    @(negedge clk) chip_en = 1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule